// File: doc/BRIEF.md
# Address-Latched ROM Bank Switcher

This block sits between a 16-bit processor memory bus and a banked cartridge ROM that is larger than the 8 KB window the bus reserves for it. It decodes every bus access against that window. When the processor writes anywhere inside the window, the block does not look at the data. Instead it stores a few low-order address bits as the bank selector. On every window access it then builds the ROM address from two parts. The 13 offset bits of the bus address form the low part. The stored bits, inverted, form the high part. The block also drives the ROM chip select.

Software changes banks with a dummy write to a chosen window address. The address bits just above the bus LSB, taken inverted, give the bank number. The bank stays selected through any number of reads, until the next window write.

The bus address is numbered LSB-first here. `bus_addr[15]` is the most significant bit and `bus_addr[0]` is the byte-select bit. A write to one word toggles `bus_addr[0]`, so the block never uses that bit. There is no data path through the block. All pins are plain, level-sensed control and address signals with no handshake.

Top module: `cart_bank_switch`

## Requirements
- R1: `rom_cs_n` is low exactly when `mem_en_n` is low and `bus_addr[15:13]` equals 3'b011 (window 0x6000..0x7FFF). Otherwise it is high. It follows the inputs in the same cycle.
- R2: `rom_addr[12:0]` equals `bus_addr[12:0]` in the same cycle.
- R3: The stored bank changes only on a capture: a clock edge where the window is selected, `wr_en_n` is low, and `wr_en_n` was high at the previous edge. Reads, writes outside the window, and writes with `mem_en_n` high leave `rom_addr[12+SEL_BITS:13]` unchanged.
- R4: From the cycle after a capture, `rom_addr[12+SEL_BITS:13]` equals the bitwise inverse of the captured `bus_addr[SEL_BITS:1]`. With SEL_BITS=3, writes to 0x600E, 0x600C, 0x6002 and 0x6000 select banks 0, 1, 6 and 7.
- R5: `bus_addr[0]` and `bus_addr[12:SEL_BITS+1]` do not affect the capture. With SEL_BITS=3, 0x7FFF selects bank 0 and 0x7FF1 selects bank 7.
- R6: A write strobe held low for several cycles captures only once, on its first cycle. Address changes later in the same strobe are ignored.
- R7: During and after reset the stored bits are all zero, so `rom_addr[12+SEL_BITS:13]` is all ones (the highest bank).
- R8: The selected bank persists across any number of window reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Processor address, bit 15 most significant |
| mem_en_n | input | 1 | Active-low memory cycle enable |
| wr_en_n | input | 1 | Active-low write strobe |
| rom_addr | output | 13+SEL_BITS | ROM address: inverted bank bits above the 13 offset bits |
| rom_cs_n | output | 1 | Active-low ROM chip select |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:

- **Bank inversion.** It checks the four bank-select writes with known results. A design that stored the bank without inverting it would reach bank 7 where bank 0 is expected.
- **Don't-care addresses.** It writes with the don't-care bits set. A bit window shifted to include `bus_addr[0]` would turn 0x7FF1 into bank 6.
- **Writes that must not capture.** It issues writes outside the window and writes with memory enable high. A design that gated on the strobe alone would change the bank on these.
- **Held strobe.** It holds the write strobe low while the address moves. A level-sensitive capture would follow the later address instead of keeping the first.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int BUS_W = 16;
  localparam int WIN_W = 13;
  localparam int TAG_W = BUS_W - WIN_W;
  localparam logic [TAG_W-1:0] WIN_TAG = 3'b011;
endpackage

// File: rtl/cbs_decode.sv
module cbs_decode
  import cbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] addr_tag,
  input  logic             mem_en_n,
  input  logic             wr_en_n,
  output logic             win_hit,
  output logic             cap_pulse
);
  // strobe level seen at the previous edge; reset as "not asserted"
  logic wr_prev_n;

  assign win_hit   = !mem_en_n && (addr_tag == WIN_TAG);
  assign cap_pulse = win_hit && !wr_en_n && wr_prev_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_prev_n <= 1'b1;
    else        wr_prev_n <= wr_en_n;
  end

  // R1: chip select path never active without memory enable
  assert_hit_needs_mem_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en_n |-> !win_hit);
endmodule

// File: rtl/cbs_bank_reg.sv
module cbs_bank_reg #(
  parameter int SEL_BITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_pulse,
  input  logic [SEL_BITS-1:0] cap_bits,
  output logic [SEL_BITS-1:0] bank_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bank_q <= '0;
    else if (cap_pulse) bank_q <= cap_bits;
  end

  // R7: register holds zero while reset is applied
  always_ff @(posedge clk) begin
    if (!rst_n) assert_reset_clear_R7: assert (bank_q == '0);
  end
endmodule

// File: rtl/cbs_addr_gen.sv
module cbs_addr_gen
  import cbs_pkg::*;
#(
  parameter int SEL_BITS = 3
) (
  input  logic [SEL_BITS-1:0]       bank_q,
  input  logic [WIN_W-1:0]          offset,
  input  logic                      win_hit,
  output logic [WIN_W+SEL_BITS-1:0] rom_addr,
  output logic                      rom_cs_n
);
  assign rom_addr = {~bank_q, offset};
  assign rom_cs_n = !win_hit;
endmodule

// File: rtl/cart_bank_switch.sv
module cart_bank_switch
  import cbs_pkg::*;
#(
  parameter int SEL_BITS = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BUS_W-1:0]          bus_addr,
  input  logic                      mem_en_n,
  input  logic                      wr_en_n,
  output logic [WIN_W+SEL_BITS-1:0] rom_addr,
  output logic                      rom_cs_n
);
  localparam int ROM_W = WIN_W + SEL_BITS;

  generate
    if (SEL_BITS < 1 || SEL_BITS > 3) begin : g_bad_sel
      $error("SEL_BITS must lie in 1..3");
    end
  endgenerate

  logic                win_hit;
  logic                cap_pulse;
  logic [SEL_BITS-1:0] bank_q;

  cbs_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_tag  (bus_addr[BUS_W-1:WIN_W]),
    .mem_en_n  (mem_en_n),
    .wr_en_n   (wr_en_n),
    .win_hit   (win_hit),
    .cap_pulse (cap_pulse)
  );

  cbs_bank_reg #(.SEL_BITS(SEL_BITS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_pulse (cap_pulse),
    .cap_bits  (bus_addr[SEL_BITS:1]),
    .bank_q    (bank_q)
  );

  cbs_addr_gen #(.SEL_BITS(SEL_BITS)) u_agen (
    .bank_q   (bank_q),
    .offset   (bus_addr[WIN_W-1:0]),
    .win_hit  (win_hit),
    .rom_addr (rom_addr),
    .rom_cs_n (rom_cs_n)
  );

  // R1: no chip select while memory enable is high
  assert_cs_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en_n |-> rom_cs_n);

  // R3: no write strobe, or outside the window -> bank field steady
  assert_bank_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_n || mem_en_n || bus_addr[BUS_W-1:WIN_W] != WIN_TAG)
      |=> $stable(rom_addr[ROM_W-1:WIN_W]));

  // R4: a capture lands inverted on the upper ROM lines next cycle
  assert_capture_inv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |=> rom_addr[ROM_W-1:WIN_W] == ~$past(bus_addr[SEL_BITS:1]));

  // R6: strobe still low from last edge -> no second capture
  assert_single_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_n && !$past(wr_en_n)) |=> $stable(rom_addr[ROM_W-1:WIN_W]));
endmodule

// File: tb/cart_bank_switch_test.sv
`timescale 1ns/1ps
module cart_bank_switch_test;
  localparam int SEL = 3;
  localparam int NB  = 1 << SEL;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        mem_en_n = 1'b1;
  logic        wr_en_n = 1'b1;
  logic [15:0] rom_addr;
  logic        rom_cs_n;

  int total = 0;
  int bad = 0;
  int m_bank = NB - 1;   // bank number reached
  bit m_prev_hi = 1'b1;  // strobe high at previous edge

  always #2 clk = ~clk;  // 250 MHz

  cart_bank_switch #(.SEL_BITS(SEL)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .mem_en_n(mem_en_n), .wr_en_n(wr_en_n),
    .rom_addr(rom_addr), .rom_cs_n(rom_cs_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive, compare every output, then advance the model
  task automatic step(input logic [15:0] a, input logic me, input logic we);
    bit hit;
    @(negedge clk);
    bus_addr = a; mem_en_n = me; wr_en_n = we;
    #1;
    hit = !me && (a[15:13] == 3'b011);
    chk("R1 chip select", int'(rom_cs_n), int'(!hit));
    chk("R2 offset", int'(rom_addr[12:0]), int'(a[12:0]));
    chk("R3 bank field", int'(rom_addr[15:13]), m_bank);
    @(posedge clk);
    if (hit && !we && m_prev_hi) m_bank = (~(int'(a) >> 1)) & (NB - 1);
    m_prev_hi = we;
  endtask

  task automatic wr(input logic [15:0] a);
    step(a, 1'b0, 1'b0);
    step(a, 1'b0, 1'b1);
  endtask

  task automatic bank_is(input string tag, input int exp);
    #1;
    chk(tag, int'(rom_addr[15:13]), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset bank", int'(rom_addr[15:13]), 7);
    chk("R1 reset cs", int'(rom_cs_n), 1);
    @(negedge clk); rst_n = 1'b1;

    step(16'h6123, 1'b0, 1'b1);
    bank_is("R7 bank after reset", 7);

    wr(16'h600E); bank_is("R4 0x600E", 0);
    wr(16'h600C); bank_is("R4 0x600C", 1);
    wr(16'h6002); bank_is("R4 0x6002", 6);
    wr(16'h6000); bank_is("R4 0x6000", 7);
    wr(16'h7FFF); bank_is("R5 0x7FFF", 0);
    wr(16'h7FF1); bank_is("R5 0x7FF1", 7);
    wr(16'h6AA7); bank_is("R5 0x6AA7", 4);

    // writes that must not capture
    wr(16'h600A); bank_is("R4 0x600A", 2);
    wr(16'h800E); bank_is("R3 write outside window", 2);
    wr(16'h5FFE); bank_is("R3 write below window", 2);
    step(16'h600E, 1'b1, 1'b0);
    step(16'h600E, 1'b1, 1'b1);
    bank_is("R3 write without mem enable", 2);

    // reads persist
    for (int i = 0; i < 20; i++) step(16'h6000 + 16'(i * 517), 1'b0, 1'b1);
    bank_is("R8 after many reads", 2);
    step(16'h600E, 1'b0, 1'b1);
    bank_is("R8 read of select address", 2);

    // held strobe: first address wins
    step(16'h600C, 1'b0, 1'b0);
    step(16'h6002, 1'b0, 1'b0);
    step(16'h600E, 1'b0, 1'b0);
    step(16'h600E, 1'b0, 1'b1);
    bank_is("R6 held strobe", 1);

    // strobe asserted first outside, then still held entering window
    step(16'h0000, 1'b1, 1'b0);
    step(16'h6002, 1'b0, 1'b0);
    step(16'h6002, 1'b0, 1'b1);
    bank_is("R6 strobe already low", 1);

    // idle bus
    step(16'h7000, 1'b1, 1'b1);
    #1 chk("R1 idle cs", int'(rom_cs_n), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule